// File: doc/BRIEF.md
# Issue Window Wakeup Array

This block holds instructions that have been dispatched but not yet issued, and tracks when their operands become available. Each slot stores two source tags, each with a readiness flag, plus a destination tag and an occupancy flag. In every cycle up to `BW` result tags arrive on broadcast lanes. Each stored source compares its tag against every lane in parallel, and any match marks that source available. A slot with both sources available raises its request line. An external selector reads those lines and answers with a grant vector.

A granted slot is emptied at the next clock edge. The block also reports the destination tag of the lowest-indexed granted slot in the same cycle, so the selector can drive it straight back onto a broadcast lane. Because of this loop, a consumer whose producer is granted in cycle t raises its request in cycle t+1. New instructions are written into the lowest-indexed empty slot. When no slot is empty, a stall is raised and the incoming instruction is dropped.

Top module: `iq_wakeup_window`

## Requirements
- R1: After reset, every slot is empty: `req` is all zero, `disp_stall` is 0 and `issue_vld` is 0.
- R2: An accepted dispatch fills the lowest-indexed empty slot (slot i drives `req[i]`), and at most one slot is filled per cycle.
- R3: A source dispatched with its ready input at 1 is stored as available. A source dispatched with its ready input at 0 is stored as waiting, unless R4 applies.
- R4: A dispatched source whose tag equals a lane tag whose valid bit is 1 in that same cycle is stored as available.
- R5: A waiting source becomes available at the clock edge after any lane has valid 1 and a tag equal to its own. Lanes with valid 0 have no effect. Once set, availability stays set until the slot is freed.
- R6: `req[i]` is 1 exactly when slot i is occupied and both of its sources are available.
- R7: A granted, occupied slot is empty from the next clock edge, and its `req` bit is 0 in the following cycle. The slot can be filled by a later dispatch.
- R8: `disp_stall` is 1 exactly when all slots are occupied. A dispatch while stalled changes no slot.
- R9: A consumer whose producer is granted in cycle t, with the producer's destination tag broadcast in cycle t, raises `req` in cycle t+1.
- R10: A grant bit on an empty slot has no effect.
- R11: `issue_vld` is 1 when some granted slot is occupied. `issue_dst` then carries the destination tag of the lowest-indexed such slot, in the same cycle as the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_src0_tag | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source is already available |
| disp_src1_tag | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source is already available |
| disp_dst_tag | input | TAG_W | Destination tag |
| disp_stall | output | 1 | No empty slot; dispatch is dropped |
| bc_valid | input | BW | Per-lane broadcast valid |
| bc_tag | input | BW*TAG_W | Broadcast tags, lane k at bits [k*TAG_W +: TAG_W] |
| req | output | WIN | Per-slot issue request |
| grant | input | WIN | Per-slot grant from the selector |
| issue_vld | output | 1 | At least one occupied slot is granted |
| issue_dst | output | TAG_W | Destination tag of the lowest granted occupied slot |

## Verification
The bench builds the block with `WIN=4` and `BW=2`. This makes the full-window stall and the refill of a freed middle slot reachable within a few dispatches. Two lanes are enough to show that a match on either lane wakes a source and that a lane with valid 0 is ignored. The producer and consumer chain, with the issued tag looped back onto a lane, exercises the single-cycle wakeup path directly.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int unsigned TAG_W = 6;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        tag_t tag;
        logic rdy;
    } src_t;

    typedef struct packed {
        logic valid;
        src_t s0;
        src_t s1;
        tag_t dst;
    } slot_t;
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match
    import iq_pkg::*;
#(
    parameter int unsigned BW = 2
) (
    input  tag_t                  tag,
    input  logic [BW-1:0]         bc_valid,
    input  logic [BW*TAG_W-1:0]   bc_tag,
    output logic                  hit
);
    logic [BW-1:0] lane_hit;

    for (genvar k = 0; k < BW; k++) begin : g_lane
        assign lane_hit[k] = bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == tag);
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
#(
    parameter int unsigned BW = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  slot_t                wr_data,
    input  logic                 clr,
    input  logic [BW-1:0]        bc_valid,
    input  logic [BW*TAG_W-1:0]  bc_tag,
    output slot_t                state,
    output logic                 req
);
    logic hit0, hit1;

    iq_tag_match #(.BW(BW)) u_m0 (
        .tag(state.s0.tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit0)
    );
    iq_tag_match #(.BW(BW)) u_m1 (
        .tag(state.s1.tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_en) begin
            state <= wr_data;
        end else begin
            if (clr)  state.valid  <= 1'b0;
            if (hit0) state.s0.rdy <= 1'b1;
            if (hit1) state.s1.rdy <= 1'b1;
        end
    end

    assign req = state.valid & state.s0.rdy & state.s1.rdy;
endmodule

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] free,
    output logic [N-1:0] onehot,
    output logic         any
);
    always_comb begin
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) onehot = N'(1) << i;
        end
    end

    assign any = |free;
endmodule

// File: rtl/iq_wakeup_window.sv
module iq_wakeup_window
    import iq_pkg::*;
#(
    parameter int unsigned WIN = 16,
    parameter int unsigned BW  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 disp_valid,
    input  logic [TAG_W-1:0]     disp_src0_tag,
    input  logic                 disp_src0_rdy,
    input  logic [TAG_W-1:0]     disp_src1_tag,
    input  logic                 disp_src1_rdy,
    input  logic [TAG_W-1:0]     disp_dst_tag,
    output logic                 disp_stall,
    input  logic [BW-1:0]        bc_valid,
    input  logic [BW*TAG_W-1:0]  bc_tag,
    output logic [WIN-1:0]       req,
    input  logic [WIN-1:0]       grant,
    output logic                 issue_vld,
    output logic [TAG_W-1:0]     issue_dst
);
    slot_t           slots [WIN];
    slot_t           wr_data;
    logic [WIN-1:0]  valid_vec;
    logic [WIN-1:0]  pick;
    logic [WIN-1:0]  live_grant;
    logic            have_free;
    logic            dhit0, dhit1;

    // Same-cycle broadcast capture for incoming sources
    iq_tag_match #(.BW(BW)) u_dm0 (
        .tag(disp_src0_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(dhit0)
    );
    iq_tag_match #(.BW(BW)) u_dm1 (
        .tag(disp_src1_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(dhit1)
    );

    always_comb begin
        wr_data.valid  = 1'b1;
        wr_data.s0.tag = disp_src0_tag;
        wr_data.s0.rdy = disp_src0_rdy | dhit0;
        wr_data.s1.tag = disp_src1_tag;
        wr_data.s1.rdy = disp_src1_rdy | dhit1;
        wr_data.dst    = disp_dst_tag;
    end

    iq_free_pick #(.N(WIN)) u_pick (
        .free(~valid_vec), .onehot(pick), .any(have_free)
    );

    assign disp_stall = ~have_free;

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        iq_slot #(.BW(BW)) u_slot (
            .clk(clk), .rst(rst),
            .wr_en(disp_valid & pick[i]),
            .wr_data(wr_data),
            .clr(grant[i]),
            .bc_valid(bc_valid), .bc_tag(bc_tag),
            .state(slots[i]),
            .req(req[i])
        );
        assign valid_vec[i]  = slots[i].valid;
        assign live_grant[i] = grant[i] & slots[i].valid;
    end

    always_comb begin
        issue_dst = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (live_grant[i]) issue_dst = slots[i].dst;
        end
    end

    assign issue_vld = |live_grant;
endmodule

// File: rtl/iq_wakeup_window_chk.sv
module iq_wakeup_window_chk #(
    parameter int unsigned WIN = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [WIN-1:0] req,
    input logic [WIN-1:0] grant,
    input logic           disp_stall,
    input logic [WIN-1:0] valid_vec
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (req == '0 && !disp_stall));

    a_r2_single_fill: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(valid_vec & ~$past(valid_vec)) <= 1));

    a_r5_req_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(req & ~grant) & ~req) == '0));

    a_r7_grant_drops_req: assert property (@(posedge clk) disable iff (rst)
        (|(grant & req)) |=> ((req & $past(grant & req)) == '0));

    a_r8_full_no_write: assert property (@(posedge clk) disable iff (rst)
        (disp_stall && grant == '0) |=> (valid_vec == $past(valid_vec)));
endmodule

bind iq_wakeup_window iq_wakeup_window_chk #(.WIN(WIN)) u_chk (
    .clk(clk), .rst(rst), .req(req), .grant(grant),
    .disp_stall(disp_stall), .valid_vec(valid_vec)
);

// File: tb/iq_wakeup_window_tb.sv
module iq_wakeup_window_tb;
    import iq_pkg::*;

    localparam int unsigned WIN = 4;
    localparam int unsigned BW  = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic                disp_valid;
    logic [TAG_W-1:0]    s0_tag, s1_tag, dst_tag;
    logic                s0_rdy, s1_rdy;
    logic                disp_stall;
    logic [BW-1:0]       bc_valid;
    logic [BW*TAG_W-1:0] bc_tag;
    logic [WIN-1:0]      req, grant;
    logic                issue_vld;
    logic [TAG_W-1:0]    issue_dst;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    iq_wakeup_window #(.WIN(WIN), .BW(BW)) u_dut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid),
        .disp_src0_tag(s0_tag), .disp_src0_rdy(s0_rdy),
        .disp_src1_tag(s1_tag), .disp_src1_rdy(s1_rdy),
        .disp_dst_tag(dst_tag), .disp_stall(disp_stall),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .req(req), .grant(grant),
        .issue_vld(issue_vld), .issue_dst(issue_dst)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic clear_in();
        disp_valid = 0; s0_tag = 0; s1_tag = 0; dst_tag = 0;
        s0_rdy = 0; s1_rdy = 0; bc_valid = 0; bc_tag = 0; grant = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic set_disp(int t0, bit r0, int t1, bit r1, int d);
        disp_valid = 1;
        s0_tag = TAG_W'(t0); s0_rdy = r0;
        s1_tag = TAG_W'(t1); s1_rdy = r1;
        dst_tag = TAG_W'(d);
    endtask

    task automatic set_bc(int lane, int t);
        bc_valid[lane] = 1'b1;
        bc_tag[lane*TAG_W +: TAG_W] = TAG_W'(t);
    endtask

    task automatic t_reset();
        check("R1 req", 32'(req), 0);
        check("R1 stall", 32'(disp_stall), 0);
        check("R1 issue_vld", 32'(issue_vld), 0);
    endtask

    task automatic t_basic();
        set_disp(1, 1, 2, 1, 5); step();
        check("R2/R3 ready dispatch to slot0", 32'(req), 32'h1);
        grant = 4'b0001; #1;
        check("R11 issue_vld", 32'(issue_vld), 1);
        check("R11 issue_dst", 32'(issue_dst), 5);
        step();
        check("R7 grant empties slot", 32'(req), 0);
    endtask

    task automatic t_wakeup();
        set_disp(1, 1, 7, 0, 6); step();
        check("R6 one source waiting", 32'(req), 0);
        bc_valid[0] = 1'b0; bc_tag[0 +: TAG_W] = TAG_W'(7); step();
        check("R5 invalid lane ignored", 32'(req), 0);
        set_bc(1, 7); step();
        check("R5 lane1 wakeup", 32'(req), 32'h1);
        step();
        check("R5 ready sticky", 32'(req), 32'h1);
        grant = 4'b0001; step();
        check("R7 cleared", 32'(req), 0);
    endtask

    task automatic t_disp_bypass();
        set_disp(12, 0, 3, 1, 8); set_bc(1, 12); step();
        check("R4 same-cycle capture", 32'(req), 32'h1);
        grant = 4'b0001; step();
    endtask

    task automatic t_full();
        for (int i = 0; i < WIN; i++) begin
            check("R8 not stalled before full", 32'(disp_stall), 0);
            set_disp(9, 0, 9, 0, 20 + i); step();
        end
        check("R8 stall when full", 32'(disp_stall), 1);
        set_disp(1, 1, 1, 1, 30); step();
        check("R8 dropped dispatch", 32'(req), 0);
        set_bc(0, 9); step();
        check("R5 broadcast wakes all", 32'(req), 32'hF);
        grant = 4'b0100; step();
        check("R7 middle slot freed", 32'(req), 32'hB);
        check("R8 stall released", 32'(disp_stall), 0);
        set_disp(1, 1, 1, 1, 31); step();
        check("R2 refill lowest free slot", 32'(req), 32'hF);
        grant = 4'b1111; step();
        check("R7 all cleared", 32'(req), 0);
    endtask

    task automatic t_back_to_back();
        set_disp(1, 1, 1, 1, 3); step();
        set_disp(3, 0, 1, 1, 4); step();
        check("R9 consumer waits", 32'(req), 32'h1);
        grant = 4'b0001; #1;
        check("R11 producer tag", 32'(issue_dst), 3);
        set_bc(0, int'(issue_dst)); step();
        check("R9 consumer next cycle", 32'(req), 32'h2);
        grant = 4'b0010; step();
    endtask

    task automatic t_grant_empty();
        set_disp(15, 0, 15, 1, 9); step();
        grant = 4'b1110; #1;
        check("R10 no issue on empty", 32'(issue_vld), 0);
        step();
        set_bc(0, 15); step();
        check("R10 occupied slot kept", 32'(req), 32'h1);
        grant = 4'b0001; step();
        check("R7 final clear", 32'(req), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_basic();
        t_wakeup();
        t_disp_bypass();
        t_full();
        t_back_to_back();
        t_grant_empty();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule